// File: doc/BRIEF.md
# Timer and Event Counter Unit

This block is an 8-bit up-counter that a small controller core uses either as an interval timer or as a counter of external events. It has two count sources, and only one drives the counter at a time. In timer mode the counter advances once every 32 instruction-cycle strobes, which a 5-bit prescaler derives. In event mode it advances on a falling transition of an external test pin. The pin is sampled only on instruction-cycle strobes: a low sample counts only after a high sample has been seen.

Three single-cycle command strobes choose the mode: start the timer, start the event counter, or stop. No command changes the count value. The start-timer command clears the prescaler, so the first timer increment comes a full prescaler period later. While the unit is stopped, the count can be loaded. A wrap from 0xFF to 0x00 gives a one-cycle overflow pulse and sets a sticky flag, which a read strobe clears. The pin level is always passed out for conditional-branch evaluation, in every mode.

Top module: `evt_tmr_unit`

## Requirements
- R1: After reset the count is 0x00, the overflow pulse and the sticky flag are 0, and the unit is stopped (no strobe or pin activity changes the count).
- R2: After a start-timer command the count increments exactly once per 32 cycles in which `cyc_stb_i` is 1. The command clears the prescaler, so the first increment takes effect on the 32nd strobe after the command, even when the timer was already running.
- R3: None of the commands (start-timer, start-counter or stop) modifies the count value.
- R4: In event mode the pin is sampled only in cycles with `cyc_stb_i` = 1. A low sample that follows a high sample increments the count by one at that clock edge. Pin changes in cycles without a strobe are ignored.
- R5: In event mode a low sample that has no preceding high sample does not count, and further low samples after a counted one do not count until a new high sample is seen.
- R6: After a stop command neither strobes nor pin activity change the count.
- R7: `load_i` writes `load_val_i` into the count at the next edge only while the unit is stopped and no command is present in that cycle. A load at any other time is ignored.
- R8: An increment from 0xFF gives 0x00. In the same cycle that the count reads 0x00, `ovf_pulse_o` is 1, for exactly one cycle, and `ovf_flag_o` becomes 1.
- R9: `ovf_flag_o` stays set until a cycle with `flag_rd_i` = 1 clears it at that edge. If an overflow occurs in the same cycle as the read, the flag remains set.
- R10: `pin_lvl_o` equals `pin_i` at all times, in every mode.
- R11: The most recent command selects the source. In the same cycle, stop beats start-timer and start-timer beats start-counter. Every command clears the edge detector's seen-high state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cyc_stb_i | input | 1 | Once-per-instruction-cycle strobe |
| pin_i | input | 1 | External test pin |
| start_tmr_i | input | 1 | Command: count prescaled strobes |
| start_evt_i | input | 1 | Command: count pin falling transitions |
| stop_i | input | 1 | Command: halt counting |
| load_i | input | 1 | Load the count (honoured only while stopped) |
| load_val_i | input | 8 | Value to load |
| flag_rd_i | input | 1 | Read strobe that clears the sticky overflow flag |
| count_o | output | 8 | Current count value |
| ovf_pulse_o | output | 1 | One-cycle wrap indication |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| pin_lvl_o | output | 1 | Test pin level for branch evaluation |

## Verification
The hardest situations to reach are an overflow in the same cycle as a flag read, and a wrap that happens while the prescaler is mid-period. With the default parameters, a natural wrap needs up to 8192 strobes. The bench avoids that wait by loading 0xFE or 0xFF while the unit is stopped. It then starts the timer and counts strobes exactly, so that the 32nd strobe falls in a chosen cycle, and it can assert the read strobe in that same cycle. To reach the seen-high clearing, the bench leaves a high sample pending, issues a command, and only then presents the low sample.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_EVENT = 2'd2
  } src_t;

  // Modulo-increment used by the prescaler: next value of a counter that wraps at lim.
  function automatic logic [31:0] wrap_inc(input logic [31:0] cur, input logic [31:0] lim);
    return (cur >= lim - 32'd1) ? 32'd0 : cur + 32'd1;
  endfunction

  // Terminal-step test: true when cur is the last step before wrapping.
  function automatic logic at_last(input logic [31:0] cur, input logic [31:0] lim);
    return cur == lim - 32'd1;
  endfunction

  // Command resolution: stop > start timer > start event; else hold.
  function automatic src_t next_src(input src_t cur, input logic stop, input logic st_tmr,
                                    input logic st_evt);
    if (stop)        return SRC_OFF;
    else if (st_tmr) return SRC_TIMER;
    else if (st_evt) return SRC_EVENT;
    else             return cur;
  endfunction

endpackage

// File: rtl/evt_tmr_ctl.sv
module evt_tmr_ctl
  import evt_tmr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_tmr_i,
  input  logic start_evt_i,
  input  logic stop_i,
  output src_t src_o,
  output logic any_cmd_o,
  output logic presc_clr_o
);

  src_t src_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) src_q <= SRC_OFF;
    else         src_q <= next_src(src_q, stop_i, start_tmr_i, start_evt_i);
  end

  assign src_o       = src_q;
  assign any_cmd_o   = start_tmr_i | start_evt_i | stop_i;
  assign presc_clr_o = start_tmr_i & ~stop_i;

endmodule

// File: rtl/evt_tmr_presc.sv
module evt_tmr_presc
  import evt_tmr_pkg::*;
#(
  parameter int unsigned DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);

  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] step_q;
  logic [31:0]   step_ext;

  assign step_ext = 32'(step_q);
  assign tick_o   = en_i & at_last(step_ext, DIV);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clr_i) step_q <= '0;
    else if (en_i)        step_q <= PW'(wrap_inc(step_ext, DIV));
  end

endmodule

// File: rtl/evt_tmr_edge.sv
module evt_tmr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic pin_i,
  output logic tick_o,
  output logic seen_hi_o
);

  logic seen_hi_q;

  assign tick_o    = en_i & ~pin_i & seen_hi_q;
  assign seen_hi_o = seen_hi_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clr_i) seen_hi_q <= 1'b0;
    else if (en_i)        seen_hi_q <= pin_i;
  end

endmodule

// File: rtl/evt_tmr_cnt.sv
module evt_tmr_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_en_i,
  input  logic [W-1:0] load_val_i,
  input  logic         flag_rd_i,
  output logic [W-1:0] count_o,
  output logic         ovf_set_o,
  output logic         ovf_pulse_o,
  output logic         ovf_flag_o
);

  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] cnt_q;
  logic         pulse_q, flag_q;

  assign ovf_set_o = inc_i & (cnt_q == CMAX);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (load_en_i)  cnt_q <= load_val_i;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
      pulse_q <= ovf_set_o;
      flag_q  <= ovf_set_o | (flag_q & ~flag_rd_i);
    end
  end

  assign count_o     = cnt_q;
  assign ovf_pulse_o = pulse_q;
  assign ovf_flag_o  = flag_q;

endmodule

// File: rtl/evt_tmr_unit.sv
module evt_tmr_unit
  import evt_tmr_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PRESC_DIV = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_stb_i,
  input  logic             pin_i,
  input  logic             start_tmr_i,
  input  logic             start_evt_i,
  input  logic             stop_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             flag_rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_pulse_o,
  output logic             ovf_flag_o,
  output logic             pin_lvl_o
);

  src_t src_w;
  logic any_cmd_w, presc_clr_w;
  logic tmr_en_w, evt_en_w;
  logic tick_tmr_w, tick_evt_w, inc_w;
  logic load_en_w, ovf_set_w, seen_hi_w, mode_off_w;

  evt_tmr_ctl ctl_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_tmr_i(start_tmr_i), .start_evt_i(start_evt_i), .stop_i(stop_i),
    .src_o(src_w), .any_cmd_o(any_cmd_w), .presc_clr_o(presc_clr_w)
  );

  // Counting is suspended in any cycle that carries a command.
  assign tmr_en_w   = cyc_stb_i & (src_w == SRC_TIMER) & ~any_cmd_w;
  assign evt_en_w   = cyc_stb_i & (src_w == SRC_EVENT) & ~any_cmd_w;
  assign mode_off_w = (src_w == SRC_OFF);
  assign load_en_w  = load_i & mode_off_w & ~any_cmd_w;

  evt_tmr_presc #(.DIV(PRESC_DIV)) presc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(presc_clr_w),
    .en_i(tmr_en_w), .tick_o(tick_tmr_w)
  );

  evt_tmr_edge edge_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(any_cmd_w),
    .en_i(evt_en_w), .pin_i(pin_i), .tick_o(tick_evt_w), .seen_hi_o(seen_hi_w)
  );

  assign inc_w = tick_tmr_w | tick_evt_w;

  evt_tmr_cnt #(.W(CNT_W)) cnt_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_w),
    .load_en_i(load_en_w), .load_val_i(load_val_i), .flag_rd_i(flag_rd_i),
    .count_o(count_o), .ovf_set_o(ovf_set_w),
    .ovf_pulse_o(ovf_pulse_o), .ovf_flag_o(ovf_flag_o)
  );

  assign pin_lvl_o = pin_i;

endmodule

// File: rtl/evt_tmr_chk.sv
module evt_tmr_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] count_o,
  input logic          ovf_pulse_o,
  input logic          ovf_flag_o,
  input logic          flag_rd_i,
  input logic          load_i,
  input logic          ovf_set_w,
  input logic          tick_tmr_w,
  input logic          tick_evt_w,
  input logic          any_cmd_w,
  input logic          mode_off_w,
  input logic          seen_hi_w
);

  // R8: pulse coincides with a zero count and is one cycle wide
  assert_pulse_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pulse_o |-> (count_o == '0) && ovf_flag_o);
  assert_pulse_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pulse_o |=> !ovf_pulse_o);

  // R9: a read without a coincident overflow clears the flag; a coincident one keeps it
  assert_flag_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && !ovf_set_w) |=> !ovf_flag_o);
  assert_flag_setwins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_w |=> ovf_flag_o);

  // R3: commands never alter the count
  assert_cmd_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_cmd_w |=> $stable(count_o));

  // R6: a stopped unit only changes via load
  assert_off_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_off_w && !load_i) |=> $stable(count_o));

  // R11: only one source may tick per cycle
  assert_one_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_tmr_w && tick_evt_w));

  // R11: commands clear the seen-high state
  assert_cmd_clr_seen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_cmd_w |=> !seen_hi_w);

  // R2/R4: without a load the count moves by at most one per cycle
  assert_step_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !$isunknown(count_o)) |=> (CW'(count_o - $past(count_o)) <= CW'(1)));

endmodule

bind evt_tmr_unit evt_tmr_chk #(.CW(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .count_o(count_o), .ovf_pulse_o(ovf_pulse_o),
  .ovf_flag_o(ovf_flag_o), .flag_rd_i(flag_rd_i), .load_i(load_i),
  .ovf_set_w(ovf_set_w), .tick_tmr_w(tick_tmr_w), .tick_evt_w(tick_evt_w),
  .any_cmd_w(any_cmd_w), .mode_off_w(mode_off_w), .seen_hi_w(seen_hi_w)
);

// File: tb/evt_tmr_unit_tb.sv
module evt_tmr_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 9;
  // Each entry: {pin sample, expected count after that strobe}; starts from 0x10 in event mode
  localparam logic [8:0] EVT_VEC [NVEC] = '{
    {1'b0, 8'h10}, {1'b1, 8'h10}, {1'b0, 8'h11}, {1'b0, 8'h11}, {1'b1, 8'h11},
    {1'b1, 8'h11}, {1'b0, 8'h12}, {1'b1, 8'h12}, {1'b0, 8'h13}
  };

  logic clk = 1'b0;
  logic rst_n, stb, pin, st_tmr, st_evt, stp, ld, frd;
  logic [7:0] ld_val;
  logic [7:0] count;
  logic ovf_pulse, ovf_flag, pin_lvl;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_tmr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_stb_i(stb), .pin_i(pin),
    .start_tmr_i(st_tmr), .start_evt_i(st_evt), .stop_i(stp),
    .load_i(ld), .load_val_i(ld_val), .flag_rd_i(frd),
    .count_o(count), .ovf_pulse_o(ovf_pulse), .ovf_flag_o(ovf_flag), .pin_lvl_o(pin_lvl)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_stb(input int n);
    stb = 1'b1;
    repeat (n) step();
    stb = 1'b0;
  endtask

  task automatic cmd(input logic t, input logic e, input logic s);
    st_tmr = t; st_evt = e; stp = s;
    step();
    st_tmr = 1'b0; st_evt = 1'b0; stp = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    ld = 1'b1; ld_val = v;
    step();
    ld = 1'b0;
  endtask

  task automatic sample(input logic p);
    pin = p;
    run_stb(1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stb = 0; pin = 0; st_tmr = 0; st_evt = 0; stp = 0; ld = 0; frd = 0; ld_val = 0;
    repeat (3) step();
    rst_n = 1'b1;
    chk("R1 count", count, 8'h00);
    chk("R1 pulse", {7'b0, ovf_pulse}, 8'h00);
    chk("R1 flag", {7'b0, ovf_flag}, 8'h00);
    sample(1'b1); sample(1'b0); run_stb(40);
    chk("R1 idle after reset", count, 8'h00);

    // R7 load while stopped, R3 start keeps count
    load(8'h10);
    chk("R7 load stopped", count, 8'h10);
    cmd(1'b0, 1'b1, 1'b0);
    chk("R3 start-counter keeps count", count, 8'h10);

    // R4/R5 table of event samples
    for (int i = 0; i < NVEC; i++) begin
      sample(EVT_VEC[i][8]);
      chk($sformatf("R4/R5 vector %0d", i), count, EVT_VEC[i][7:0]);
    end

    // R10 pin level passes through
    pin = 1'b1; #1;
    chk("R10 pin high", {7'b0, pin_lvl}, 8'h01);
    pin = 1'b0; #1;
    chk("R10 pin low", {7'b0, pin_lvl}, 8'h00);

    // R4 pin toggles without a strobe are ignored
    pin = 1'b1; step(); pin = 1'b0; step();
    sample(1'b0);
    chk("R4 no strobe no count", count, 8'h13);

    // R6 stop halts
    cmd(1'b0, 1'b0, 1'b1);
    chk("R3 stop keeps count", count, 8'h13);
    sample(1'b1); sample(1'b0);
    chk("R6 stopped ignores pin", count, 8'h13);

    // R2 timer period and wrap, R8 overflow
    load(8'hFE);
    cmd(1'b1, 1'b0, 1'b0);
    run_stb(31);
    chk("R2 31 strobes", count, 8'hFE);
    run_stb(1);
    chk("R2 32nd strobe", count, 8'hFF);
    run_stb(31);
    chk("R2 no early wrap", count, 8'hFF);
    run_stb(1);
    chk("R8 wrap count", count, 8'h00);
    chk("R8 pulse", {7'b0, ovf_pulse}, 8'h01);
    chk("R8 flag set", {7'b0, ovf_flag}, 8'h01);
    step();
    chk("R8 pulse one cycle", {7'b0, ovf_pulse}, 8'h00);
    chk("R9 flag sticky", {7'b0, ovf_flag}, 8'h01);
    frd = 1'b1; step(); frd = 1'b0;
    chk("R9 read clears", {7'b0, ovf_flag}, 8'h00);

    // R7 load ignored while running
    load(8'h55);
    chk("R7 load ignored running", count, 8'h00);

    // R2 restart clears prescaler
    run_stb(20);
    cmd(1'b1, 1'b0, 1'b0);
    run_stb(31);
    chk("R2 restart no early tick", count, 8'h00);
    run_stb(1);
    chk("R2 restart tick", count, 8'h01);

    // R11 stop beats start-timer
    cmd(1'b1, 1'b0, 1'b1);
    run_stb(40);
    chk("R11 stop priority", count, 8'h01);

    // R9 overflow in a read cycle keeps flag
    load(8'hFF);
    cmd(1'b1, 1'b0, 1'b0);
    run_stb(31);
    frd = 1'b1; stb = 1'b1; step(); frd = 1'b0; stb = 1'b0;
    chk("R9 set wins count", count, 8'h00);
    chk("R9 set wins flag", {7'b0, ovf_flag}, 8'h01);
    frd = 1'b1; step(); frd = 1'b0;

    // R8 wrap in event mode
    cmd(1'b0, 1'b0, 1'b1);
    load(8'hFF);
    cmd(1'b0, 1'b1, 1'b0);
    sample(1'b1); sample(1'b0);
    chk("R8 event wrap", count, 8'h00);
    chk("R8 event pulse", {7'b0, ovf_pulse}, 8'h01);

    // R11 commands clear seen-high
    sample(1'b1);
    cmd(1'b0, 1'b1, 1'b0);
    sample(1'b0);
    chk("R11 reissue clears seen-high", count, 8'h00);
    sample(1'b1);
    cmd(1'b1, 1'b0, 1'b0);
    cmd(1'b0, 1'b1, 1'b0);
    sample(1'b0);
    chk("R11 switch clears seen-high", count, 8'h00);
    sample(1'b1); sample(1'b0);
    chk("R11 event source selected", count, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule